// File: doc/BRIEF.md
# Staged Power Switch Ramp Sequencer

This block drives the 8-bit control word of one processor core's power switch. The switch is opened gradually so that inrush current is spread over time: each write clears more bits of the word, and every write is followed by a fixed pause before the next. Closing the switch is a single write followed by one pause. A word of 0x00 means the clamp is fully open; 0xFF means it is fully closed.

A caller pulses `start` with `enable` high (open) or low (close). The sequencer reports `busy` while a sequence is running and emits a one-cycle `done` pulse once the final pause ends. If an open request finds the word already at 0x00, no write is made and `done` is pulsed at once. The pause length is derived from a clock-rate parameter, so the same RTL serves any core clock. The current word is always visible on `swWord`, which serves as the readback.

Top module: `pwr_ramp_seq`

## Requirements
- R1: After reset `swWord` is 0xFF (closed), `busy` is 0 and `done` is 0.
- R2: An accepted open request (`start`=1, `enable`=1) with `swWord` not equal to 0x00 drives `swWord` through 0xFF, 0xFE, 0xF8, 0xF0, 0x00 in that order, with no other values in between.
- R3: Each value written by a sequence stays on `swWord` for exactly PAUSE_US*CLK_MHZ cycles, the last value included, before the next write or the end of the sequence; the first write appears on the cycle after the request edge.
- R4: An open request that finds `swWord` at 0x00 makes no write, keeps `busy` low, and pulses `done` on the cycle after the request edge.
- R5: An accepted close request (`start`=1, `enable`=0) writes 0xFF once and holds it for one pause, whether the switch was open or already closed.
- R6: `done` is high for exactly one cycle, on the cycle after the final pause ends; `busy` is high from the first write until that cycle and low while `done` is high.
- R7: A `start` pulse while `busy` is high is ignored: the running sequence keeps its values and timing and no extra sequence follows.
- R8: Closing from fully open goes from 0x00 directly to 0xFF with no intermediate word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, sampled when idle |
| enable | input | 1 | Request kind: 1 opens the switch, 0 closes it |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle completion pulse |
| swWord | output | 8 | Power switch control word and its readback |

## Verification
The bench builds the block with CLK_MHZ=2 and PAUSE_US=10, so each pause is 20 cycles and a full open ramp completes in about a hundred cycles. At that size every cycle of every sequence is compared against an arithmetically derived expected word, busy and done value, covering open from closed, open when already open, close from open and from closed, and stray requests injected mid-sequence in both directions.

// File: rtl/pwr_ramp_pkg.sv
package pwr_ramp_pkg;

  localparam int RAMP_STEPS = 5;
  localparam logic [7:0] WORD_CLOSED = 8'hFF;
  localparam logic [7:0] WORD_OPEN   = 8'h00;

  // Strobes passed from the sequencer FSM to the datapath.
  typedef struct packed {
    logic       wordWrite;
    logic [7:0] wordVal;
    logic       timerLoad;
  } ramp_stb_t;

  // Opening ramp: each step clears more of the clamp word.
  function automatic logic [7:0] rampWord(input logic [2:0] stepIdx);
    case (stepIdx)
      3'd0:    rampWord = 8'hFF;
      3'd1:    rampWord = 8'hFE;
      3'd2:    rampWord = 8'hF8;
      3'd3:    rampWord = 8'hF0;
      default: rampWord = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/pwr_ramp_dp.sv
module pwr_ramp_dp
  import pwr_ramp_pkg::*;
#(
  parameter int CLK_MHZ  = 100,
  parameter int PAUSE_US = 10
) (
  input  logic      clk,
  input  logic      rstN,
  input  ramp_stb_t stb,
  output logic [7:0] swWord,
  output logic      timerZero,
  output logic      wordOpen
);

  localparam int RELOAD = PAUSE_US * CLK_MHZ - 1;
  localparam int TW     = $clog2(RELOAD + 1);

  logic [TW-1:0] timerCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      swWord <= WORD_CLOSED;
    end else if (stb.wordWrite) begin
      swWord <= stb.wordVal;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timerCnt <= '0;
    end else if (stb.timerLoad) begin
      timerCnt <= TW'(RELOAD);
    end else if (timerCnt != '0) begin
      timerCnt <= timerCnt - 1'b1;
    end
  end

  assign timerZero = (timerCnt == '0);
  assign wordOpen  = (swWord == WORD_OPEN);

  // R2 / R8: the word only moves along the ramp or jumps back to closed.
  a_r2_legal_step: assert property (@(posedge clk) disable iff (!rstN)
    (swWord != $past(swWord)) |->
      (swWord == WORD_CLOSED) ||
      ($past(swWord) == 8'hFF && swWord == 8'hFE) ||
      ($past(swWord) == 8'hFE && swWord == 8'hF8) ||
      ($past(swWord) == 8'hF8 && swWord == 8'hF0) ||
      ($past(swWord) == 8'hF0 && swWord == 8'h00));

  // R3: a new pause is only started once the previous one has run out.
  a_r3_reload_at_zero: assert property (@(posedge clk) disable iff (!rstN)
    stb.timerLoad |-> timerZero);

  // R3: the word never changes while a pause is still counting.
  a_r3_hold_during_pause: assert property (@(posedge clk) disable iff (!rstN)
    !timerZero |=> $stable(swWord));

endmodule

// File: rtl/pwr_ramp_ctrl.sv
module pwr_ramp_ctrl
  import pwr_ramp_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      enable,
  input  logic      wordOpen,
  input  logic      timerZero,
  output ramp_stb_t stb,
  output logic      busy,
  output logic      done
);

  typedef enum logic {S_IDLE, S_WAIT} state_t;

  state_t     state, stateNext;
  logic [2:0] stepIdx, stepIdxNext;
  logic       closing, closingNext;
  logic       doneNext;

  always_comb begin
    stb         = '0;
    stateNext   = state;
    stepIdxNext = stepIdx;
    closingNext = closing;
    doneNext    = 1'b0;
    case (state)
      S_IDLE: begin
        if (start) begin
          if (enable && wordOpen) begin
            doneNext = 1'b1;
          end else begin
            // Both request kinds begin by writing the closed word.
            stb.wordWrite = 1'b1;
            stb.wordVal   = WORD_CLOSED;
            stb.timerLoad = 1'b1;
            stepIdxNext   = 3'd0;
            closingNext   = !enable;
            stateNext     = S_WAIT;
          end
        end
      end
      S_WAIT: begin
        if (timerZero) begin
          if (closing || stepIdx == 3'(RAMP_STEPS - 1)) begin
            doneNext  = 1'b1;
            stateNext = S_IDLE;
          end else begin
            stepIdxNext   = stepIdx + 3'd1;
            stb.wordWrite = 1'b1;
            stb.wordVal   = rampWord(stepIdx + 3'd1);
            stb.timerLoad = 1'b1;
          end
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      stepIdx <= '0;
      closing <= 1'b0;
      done    <= 1'b0;
    end else begin
      state   <= stateNext;
      stepIdx <= stepIdxNext;
      closing <= closingNext;
      done    <= doneNext;
    end
  end

  assign busy = (state == S_WAIT);

  // R6: completion is a single-cycle pulse.
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R6: never busy and done together.
  a_r6_busy_excl_done: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !done);

  // R4: an open request on an open switch completes at once.
  a_r4_open_skip: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && start && enable && wordOpen) |=> (done && !busy));

  // R7: a request while busy does not restart the step count.
  a_r7_busy_ignore: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !timerZero) |=> $stable(stepIdx));

endmodule

// File: rtl/pwr_ramp_seq.sv
module pwr_ramp_seq
  import pwr_ramp_pkg::*;
#(
  parameter int CLK_MHZ  = 100,
  parameter int PAUSE_US = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       enable,
  output logic       busy,
  output logic       done,
  output logic [7:0] swWord
);

  ramp_stb_t stb;
  logic      timerZero;
  logic      wordOpen;

  pwr_ramp_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .enable    (enable),
    .wordOpen  (wordOpen),
    .timerZero (timerZero),
    .stb       (stb),
    .busy      (busy),
    .done      (done)
  );

  pwr_ramp_dp #(
    .CLK_MHZ  (CLK_MHZ),
    .PAUSE_US (PAUSE_US)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .swWord    (swWord),
    .timerZero (timerZero),
    .wordOpen  (wordOpen)
  );

endmodule

// File: tb/pwr_ramp_seq_bench.sv
`timescale 1ns/1ps
module pwr_ramp_seq_bench;

  localparam int CLK_MHZ  = 2;
  localparam int PAUSE_US = 10;
  localparam int N        = CLK_MHZ * PAUSE_US;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic       enable = 1'b0;
  logic       busy;
  logic       done;
  logic [7:0] swWord;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  pwr_ramp_seq #(.CLK_MHZ(CLK_MHZ), .PAUSE_US(PAUSE_US)) u_pwr_ramp_seq (
    .clk(clk), .rstN(rstN), .start(start), .enable(enable),
    .busy(busy), .done(done), .swWord(swWord)
  );

  function automatic logic [7:0] expRamp(input int idx);
    case (idx)
      0: expRamp = 8'hFF;
      1: expRamp = 8'hFE;
      2: expRamp = 8'hF8;
      3: expRamp = 8'hF0;
      default: expRamp = 8'h00;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Issue one request and follow it cycle by cycle. injectAt > 0 pulses a
  // stray request of kind injEn at that sample while the sequence runs (R7).
  task automatic runOp(input bit en, input bit fromOpen, input int injectAt,
                       input bit injEn);
    int nWrites;
    int total;
    logic [7:0] expW;
    nWrites = (en && fromOpen) ? 0 : (en ? 5 : 1);
    total   = nWrites * N;
    @(negedge clk);
    start = 1'b1; enable = en;
    for (int s = 1; s <= total + 2; s++) begin
      @(negedge clk);
      start = 1'b0;
      if (s == injectAt) begin
        start = 1'b1; enable = injEn;
      end
      if (s <= total) begin
        expW = en ? expRamp((s - 1) / N) : 8'hFF;
        chk(swWord == expW, en ? "R2/R3 ramp word" : "R5/R8 close word", swWord, expW);
        chk(busy == 1'b1, "R6 busy during sequence", busy, 1);
        chk(done == 1'b0, "R6 no early done", done, 0);
      end else if (s == total + 1) begin
        expW = en ? 8'h00 : 8'hFF;
        chk(done == 1'b1, (nWrites == 0) ? "R4 immediate done" : "R6 done after pause", done, 1);
        chk(busy == 1'b0, "R6 busy low at done", busy, 0);
        chk(swWord == expW, (nWrites == 0) ? "R4 no write" : "R3 final word", swWord, expW);
      end else begin
        expW = en ? 8'h00 : 8'hFF;
        chk(done == 1'b0, "R6 done one cycle", done, 0);
        chk(busy == 1'b0, "R7 no extra sequence", busy, 0);
        chk(swWord == expW, "R7 word stays", swWord, expW);
      end
    end
    start = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(swWord == 8'hFF, "R1 reset word", swWord, 8'hFF);
    chk(busy == 1'b0, "R1 reset busy", busy, 0);
    chk(done == 1'b0, "R1 reset done", done, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(swWord == 8'hFF, "R1 idle after reset", swWord, 8'hFF);

    runOp(1'b1, 1'b0, 7, 1'b0);      // R2 R3 R7: open from closed, stray close
    runOp(1'b1, 1'b1, 0, 1'b0);      // R4: open when already open
    runOp(1'b0, 1'b0, 5, 1'b1);      // R5 R8 R7: close from open, stray open
    runOp(1'b0, 1'b0, 0, 1'b0);      // R5: close when already closed
    runOp(1'b1, 1'b0, 3 * N, 1'b1);  // R2 R7: open again, stray open at step edge
    runOp(1'b0, 1'b0, N, 1'b0);      // R5 R7: close, stray close on last pause cycle

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule